// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline may move on to execute. It compares the register operands that the decode-stage instruction actually reads against the destinations of the instructions now in execute and in memory access. The comparison rules depend on three configuration bits, one for each forwarding path the datapath may have: ALU-result forwarding, store-data forwarding and forwarding into the zero-test comparator. A producer that has reached write-back is never compared. The register file writes in the first half of a cycle and reads in the second half, so that producer is already visible.

The unit has no state. Its outputs feed the pipeline registers directly. It injects a bubble into the decode-to-execute register by clearing every enable that bubble could carry. It freezes the decode register and the program counter for a data stall. For a control stall, which the decode stage signals when the computed target differs from the fetched path, it freezes only the decode register and lets the program counter load the corrected target.

Top module: `hazard_interlock`

## Requirements
- R1: With no matching producer and no target mismatch, `issue_nop`=0, `pc_en`=1, `id_en`=1, `pc_redirect`=0, and the three next-execute enables equal the decode-stage enables.
- R2: On any data stall, `issue_nop`=1, `id_en`=0, `pc_en`=0 and `pc_redirect`=0.
- R3: With `cfg_fwd_alu`=0, an ordinary operand stalls when the execute or the memory-access instruction writes its register. Ordinary operands are both sources of class 1, the source of class 2, the address of class 3 and the address (rs1) of class 4.
- R4: With `cfg_fwd_alu`=1, an ordinary operand stalls only when the execute-stage producer is a load. A load followed directly by its consumer therefore costs one stall cycle with forwarding and two without.
- R5: A register-indirect jump (class 6) stalls on its rs1 whenever execute or memory access writes that register, whatever the configuration.
- R6: A zero-test branch (class 5) stalls on its rs1 when execute or memory access writes it and `cfg_fwd_zero`=0. With `cfg_fwd_zero`=1, it stalls only on a load in execute.
- R7: The store data operand (rs2 of class 4) stalls on a pending write in execute or memory access when `cfg_fwd_store`=0. With `cfg_fwd_store`=1, it stalls only on a load in execute.
- R8: A target mismatch (`id_mispredict`=1) with no data stall gives `issue_nop`=1, `id_en`=0, `pc_en`=1 and `pc_redirect`=1.
- R9: Register 0 never matches. A producer whose write flag is 0 never matches. A source register that the class does not read never stalls: class 0 and class 7 read none, and class 2, 3, 5 and 6 read rs1 only.
- R10: Whenever `issue_nop`=1, all three next-execute enables are 0.
- R11: A data stall takes precedence over a target mismatch (`pc_redirect`=0, `pc_en`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_cls | input | 3 | Class of the decode-stage instruction (encodings in R3 to R9) |
| id_rs1 | input | REG_AW | First source register in decode |
| id_rs2 | input | REG_AW | Second source register in decode |
| id_mispredict | input | 1 | Computed target differs from the fetched path |
| id_reg_we | input | 1 | Decode instruction writes a register |
| id_mem_re | input | 1 | Decode instruction reads memory |
| id_mem_we | input | 1 | Decode instruction writes memory |
| ex_rd | input | REG_AW | Destination of the execute-stage instruction |
| ex_reg_we | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ma_rd | input | REG_AW | Destination of the memory-access instruction |
| ma_reg_we | input | 1 | Memory-access instruction writes a register |
| cfg_fwd_alu | input | 1 | ALU-result forwarding present |
| cfg_fwd_store | input | 1 | Store-data forwarding present |
| cfg_fwd_zero | input | 1 | Zero-comparator forwarding present |
| issue_nop | output | 1 | Insert a bubble into the decode-to-execute register |
| pc_en | output | 1 | Program counter may load |
| pc_redirect | output | 1 | Program counter loads the corrected target (control stall) |
| id_en | output | 1 | Decode register and its PC copy may load |
| ex_reg_we_nxt | output | 1 | Register-write enable into execute |
| ex_mem_re_nxt | output | 1 | Memory-read enable into execute |
| ex_mem_we_nxt | output | 1 | Memory-write enable into execute |

## Verification
The bench builds the unit with the default REG_AW of 5. That gives 32 registers, so both register 0 and the all-ones index 31 can be exercised, and the index comparators are checked at both ends of their range. Every forwarding configuration that a rule depends on is toggled inside the same scenario, so one input pattern shows the stall appearing and disappearing. The two-cycle and one-cycle load-use costs are replayed as stage-by-stage sequences.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_ALU_RR = 3'd1,
    CLS_ALU_RI = 3'd2,
    CLS_LOAD   = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_BRZ    = 3'd5,
    CLS_JREG   = 3'd6,
    CLS_JUMP   = 3'd7
  } icls_e;

  // How a source operand is consumed, which picks the forwarding path that covers it
  typedef enum logic [1:0] {
    ROLE_GEN    = 2'd0,
    ROLE_STDATA = 2'd1,
    ROLE_ZTEST  = 2'd2,
    ROLE_JTGT   = 2'd3
  } src_role_e;

  typedef struct packed {
    logic      used;
    src_role_e role;
  } src_use_t;

  // idx 0 = rs1, idx 1 = rs2
  function automatic src_use_t decode_use(input icls_e cls, input int idx);
    src_use_t u;
    u.used = 1'b0;
    u.role = ROLE_GEN;
    case (cls)
      CLS_ALU_RR: u.used = 1'b1;
      CLS_ALU_RI, CLS_LOAD: u.used = (idx == 0);
      CLS_STORE: begin
        u.used = 1'b1;
        u.role = (idx == 0) ? ROLE_GEN : ROLE_STDATA;
      end
      CLS_BRZ: begin
        u.used = (idx == 0);
        u.role = ROLE_ZTEST;
      end
      CLS_JREG: begin
        u.used = (idx == 0);
        u.role = ROLE_JTGT;
      end
      default: u.used = 1'b0;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/hz_dep_check.sv
module hz_dep_check #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic [REG_AW-1:0] ma_rd,
  input  logic              ma_we,
  output logic              hit_ex,
  output logic              hit_ma
);

  logic src_live;

  always_comb begin
    src_live = |src;
    hit_ex   = src_live && ex_we && (ex_rd == src);
    hit_ma   = src_live && ma_we && (ma_rd == src);
  end

endmodule

// File: rtl/hz_src_rule.sv
module hz_src_rule
  import hz_pkg::*;
(
  input  src_use_t use_i,
  input  logic     hit_ex,
  input  logic     hit_ma,
  input  logic     ex_is_load,
  input  logic     cfg_fwd_alu,
  input  logic     cfg_fwd_store,
  input  logic     cfg_fwd_zero,
  output logic     stall
);

  logic path_fwd;

  always_comb begin
    case (use_i.role)
      ROLE_GEN:    path_fwd = cfg_fwd_alu;
      ROLE_STDATA: path_fwd = cfg_fwd_store;
      ROLE_ZTEST:  path_fwd = cfg_fwd_zero;
      default:     path_fwd = 1'b0;
    endcase
    if (!use_i.used)
      stall = 1'b0;
    else if (path_fwd)
      stall = hit_ex && ex_is_load;
    else
      stall = hit_ex || hit_ma;
  end

endmodule

// File: rtl/hz_ex_gate.sv
module hz_ex_gate (
  input  logic bubble,
  input  logic reg_we_in,
  input  logic mem_re_in,
  input  logic mem_we_in,
  output logic reg_we_out,
  output logic mem_re_out,
  output logic mem_we_out
);

  always_comb begin
    reg_we_out = reg_we_in && !bubble;
    mem_re_out = mem_re_in && !bubble;
    mem_we_out = mem_we_in && !bubble;
  end

endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [2:0]        id_cls,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_mispredict,
  input  logic              id_reg_we,
  input  logic              id_mem_re,
  input  logic              id_mem_we,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_reg_we,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] ma_rd,
  input  logic              ma_reg_we,
  input  logic              cfg_fwd_alu,
  input  logic              cfg_fwd_store,
  input  logic              cfg_fwd_zero,
  output logic              issue_nop,
  output logic              pc_en,
  output logic              pc_redirect,
  output logic              id_en,
  output logic              ex_reg_we_nxt,
  output logic              ex_mem_re_nxt,
  output logic              ex_mem_we_nxt
);

  localparam int NSRC = 2;

  icls_e             cls;
  logic [REG_AW-1:0] src_reg   [NSRC];
  logic [NSRC-1:0]   src_stall;
  logic              data_stall;
  logic              bubble;

  assign cls        = icls_e'(id_cls);
  assign src_reg[0] = id_rs1;
  assign src_reg[1] = id_rs2;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic     hit_ex;
    logic     hit_ma;
    src_use_t use_k;

    assign use_k = decode_use(cls, k);

    hz_dep_check #(.REG_AW(REG_AW)) u_dep (
      .src    (src_reg[k]),
      .ex_rd  (ex_rd),
      .ex_we  (ex_reg_we),
      .ma_rd  (ma_rd),
      .ma_we  (ma_reg_we),
      .hit_ex (hit_ex),
      .hit_ma (hit_ma)
    );

    hz_src_rule u_rule (
      .use_i         (use_k),
      .hit_ex        (hit_ex),
      .hit_ma        (hit_ma),
      .ex_is_load    (ex_is_load),
      .cfg_fwd_alu   (cfg_fwd_alu),
      .cfg_fwd_store (cfg_fwd_store),
      .cfg_fwd_zero  (cfg_fwd_zero),
      .stall         (src_stall[k])
    );
  end

  // Data stalls win: a target cannot be trusted while its operand is pending
  always_comb begin
    data_stall  = |src_stall;
    bubble      = data_stall || id_mispredict;
    issue_nop   = bubble;
    id_en       = !bubble;
    pc_en       = !data_stall;
    pc_redirect = id_mispredict && !data_stall;
  end

  hz_ex_gate u_gate (
    .bubble     (bubble),
    .reg_we_in  (id_reg_we),
    .mem_re_in  (id_mem_re),
    .mem_we_in  (id_mem_we),
    .reg_we_out (ex_reg_we_nxt),
    .mem_re_out (ex_mem_re_nxt),
    .mem_we_out (ex_mem_we_nxt)
  );

endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk #(
  parameter int REG_AW = 5
) (
  input logic [2:0]        id_cls,
  input logic [REG_AW-1:0] id_rs1,
  input logic [REG_AW-1:0] id_rs2,
  input logic              id_mispredict,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_reg_we,
  input logic [REG_AW-1:0] ma_rd,
  input logic              ma_reg_we,
  input logic              issue_nop,
  input logic              pc_en,
  input logic              pc_redirect,
  input logic              id_en,
  input logic              ex_reg_we_nxt,
  input logic              ex_mem_re_nxt,
  input logic              ex_mem_we_nxt
);

  logic jreg_pending;

  always_comb begin
    jreg_pending = (id_cls == 3'd6) && (id_rs1 != '0) &&
                   ((ex_reg_we && ex_rd == id_rs1) || (ma_reg_we && ma_rd == id_rs1));

    p_redirect_is_ctl_r8: assert (!pc_redirect || (id_mispredict && pc_en && issue_nop && !id_en));
    p_bubble_clears_r10: assert (!issue_nop || (!ex_reg_we_nxt && !ex_mem_re_nxt && !ex_mem_we_nxt));
    p_jreg_waits_r5: assert (!jreg_pending || (issue_nop && !pc_en && !pc_redirect));
    p_reg_zero_free_r9: assert (!(id_rs1 == '0 && id_rs2 == '0 && !id_mispredict) || !issue_nop);
    p_quiet_flow_r1: assert (!(!ex_reg_we && !ma_reg_we && !id_mispredict) || (pc_en && id_en && !issue_nop));
    p_pc_frozen_r2: assert (id_en || pc_redirect || !pc_en);
  end

endmodule

bind hazard_interlock hazard_interlock_chk #(.REG_AW(REG_AW)) u_chk (
  .id_cls        (id_cls),
  .id_rs1        (id_rs1),
  .id_rs2        (id_rs2),
  .id_mispredict (id_mispredict),
  .ex_rd         (ex_rd),
  .ex_reg_we     (ex_reg_we),
  .ma_rd         (ma_rd),
  .ma_reg_we     (ma_reg_we),
  .issue_nop     (issue_nop),
  .pc_en         (pc_en),
  .pc_redirect   (pc_redirect),
  .id_en         (id_en),
  .ex_reg_we_nxt (ex_reg_we_nxt),
  .ex_mem_re_nxt (ex_mem_re_nxt),
  .ex_mem_we_nxt (ex_mem_we_nxt)
);

// File: tb/hazard_interlock_test.sv
module hazard_interlock_test;

  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]    id_cls;
  logic [AW-1:0] id_rs1, id_rs2, ex_rd, ma_rd;
  logic id_mispredict, id_reg_we, id_mem_re, id_mem_we;
  logic ex_reg_we, ex_is_load, ma_reg_we;
  logic cfg_fwd_alu, cfg_fwd_store, cfg_fwd_zero;
  logic issue_nop, pc_en, pc_redirect, id_en;
  logic ex_reg_we_nxt, ex_mem_re_nxt, ex_mem_we_nxt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  hazard_interlock #(.REG_AW(AW)) uut (
    .id_cls(id_cls), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_mispredict(id_mispredict),
    .id_reg_we(id_reg_we), .id_mem_re(id_mem_re), .id_mem_we(id_mem_we),
    .ex_rd(ex_rd), .ex_reg_we(ex_reg_we), .ex_is_load(ex_is_load),
    .ma_rd(ma_rd), .ma_reg_we(ma_reg_we),
    .cfg_fwd_alu(cfg_fwd_alu), .cfg_fwd_store(cfg_fwd_store), .cfg_fwd_zero(cfg_fwd_zero),
    .issue_nop(issue_nop), .pc_en(pc_en), .pc_redirect(pc_redirect), .id_en(id_en),
    .ex_reg_we_nxt(ex_reg_we_nxt), .ex_mem_re_nxt(ex_mem_re_nxt), .ex_mem_we_nxt(ex_mem_we_nxt)
  );

  task automatic idle_inputs();
    id_cls = 3'd0; id_rs1 = '0; id_rs2 = '0; id_mispredict = 1'b0;
    id_reg_we = 1'b0; id_mem_re = 1'b0; id_mem_we = 1'b0;
    ex_rd = '0; ex_reg_we = 1'b0; ex_is_load = 1'b0;
    ma_rd = '0; ma_reg_we = 1'b0;
    cfg_fwd_alu = 1'b0; cfg_fwd_store = 1'b0; cfg_fwd_zero = 1'b0;
  endtask

  // {issue_nop, pc_en, id_en, pc_redirect}
  localparam logic [3:0] FLOW = 4'b0110;
  localparam logic [3:0] DSTL = 4'b1000;
  localparam logic [3:0] CSTL = 4'b1101;

  task automatic expect_ctl(input logic [3:0] exp, input string tag);
    logic [3:0] got;
    got = {issue_nop, pc_en, id_en, pc_redirect};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: nop/pc/id/redir got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic expect_ex(input logic [2:0] exp, input string tag);
    logic [2:0] got;
    got = {ex_reg_we_nxt, ex_mem_re_nxt, ex_mem_we_nxt};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: ex enables got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic prod_ex(input logic [AW-1:0] r, input logic ld);
    ex_rd = r; ex_reg_we = 1'b1; ex_is_load = ld;
  endtask

  task automatic t_reset_idle();
    @(negedge clk); idle_inputs(); settle();
    expect_ctl(FLOW, "R1 idle");
    expect_ex(3'b000, "R1 idle ex");
    @(negedge clk); id_cls = 3'd3; id_rs1 = 5'd4; id_reg_we = 1'b1; id_mem_re = 1'b1;
    prod_ex(5'd9, 1'b0); ma_rd = 5'd10; ma_reg_we = 1'b1; settle();
    expect_ctl(FLOW, "R1 unrelated producers");
    expect_ex(3'b110, "R1 enables pass");
  endtask

  task automatic t_alu_nofwd();
    @(negedge clk); idle_inputs(); id_cls = 3'd1; id_rs1 = 5'd3; id_rs2 = 5'd7;
    prod_ex(5'd7, 1'b0); settle();
    expect_ctl(DSTL, "R3 rs2 vs EX");
    @(negedge clk); ex_reg_we = 1'b0; ma_rd = 5'd3; ma_reg_we = 1'b1; settle();
    expect_ctl(DSTL, "R3 rs1 vs MA");
    @(negedge clk); id_cls = 3'd4; id_rs1 = 5'd31; id_rs2 = 5'd0; ma_rd = 5'd31; settle();
    expect_ctl(DSTL, "R3 store addr reg31 vs MA");
  endtask

  task automatic t_alu_fwd();
    int stalls;
    @(negedge clk); idle_inputs(); cfg_fwd_alu = 1'b1;
    id_cls = 3'd1; id_rs1 = 5'd5; prod_ex(5'd5, 1'b0); settle();
    expect_ctl(FLOW, "R4 ALU in EX forwarded");
    @(negedge clk); ex_reg_we = 1'b0; ma_rd = 5'd5; ma_reg_we = 1'b1; settle();
    expect_ctl(FLOW, "R4 MA forwarded");
    // load-use sequence with forwarding: load in EX then in MA
    stalls = 0;
    @(negedge clk); ma_reg_we = 1'b0; id_cls = 3'd2; id_rs1 = 5'd6; prod_ex(5'd6, 1'b1); settle();
    if (issue_nop) stalls++;
    @(negedge clk); ex_reg_we = 1'b0; ex_is_load = 1'b0; ma_rd = 5'd6; ma_reg_we = 1'b1; settle();
    if (issue_nop) stalls++;
    n_chk++;
    if (stalls != 1) begin n_bad++; $display("FAIL R4 load-use fwd: stalls got %0d expected 1", stalls); end
    // same without forwarding
    stalls = 0;
    @(negedge clk); cfg_fwd_alu = 1'b0; ma_reg_we = 1'b0; prod_ex(5'd6, 1'b1); settle();
    if (issue_nop) stalls++;
    @(negedge clk); ex_reg_we = 1'b0; ma_rd = 5'd6; ma_reg_we = 1'b1; settle();
    if (issue_nop) stalls++;
    @(negedge clk); ma_reg_we = 1'b0; settle();
    if (issue_nop) stalls++;
    n_chk++;
    if (stalls != 2) begin n_bad++; $display("FAIL R4 load-use nofwd: stalls got %0d expected 2", stalls); end
  endtask

  task automatic t_jreg();
    @(negedge clk); idle_inputs(); cfg_fwd_alu = 1'b1; cfg_fwd_store = 1'b1; cfg_fwd_zero = 1'b1;
    id_cls = 3'd6; id_rs1 = 5'd12; prod_ex(5'd12, 1'b0); settle();
    expect_ctl(DSTL, "R5 jreg vs EX all fwd");
    @(negedge clk); ex_reg_we = 1'b0; ma_rd = 5'd12; ma_reg_we = 1'b1; settle();
    expect_ctl(DSTL, "R5 jreg vs MA all fwd");
  endtask

  task automatic t_brz();
    @(negedge clk); idle_inputs(); cfg_fwd_alu = 1'b1;
    id_cls = 3'd5; id_rs1 = 5'd8; ma_rd = 5'd8; ma_reg_we = 1'b1; settle();
    expect_ctl(DSTL, "R6 brz no zero fwd");
    @(negedge clk); cfg_fwd_zero = 1'b1; settle();
    expect_ctl(FLOW, "R6 brz zero fwd MA");
    @(negedge clk); ma_reg_we = 1'b0; prod_ex(5'd8, 1'b1); settle();
    expect_ctl(DSTL, "R6 brz zero fwd load EX");
  endtask

  task automatic t_store();
    @(negedge clk); idle_inputs(); cfg_fwd_alu = 1'b1;
    id_cls = 3'd4; id_rs1 = 5'd2; id_rs2 = 5'd9; prod_ex(5'd9, 1'b0); settle();
    expect_ctl(DSTL, "R7 store data no store fwd");
    @(negedge clk); cfg_fwd_store = 1'b1; settle();
    expect_ctl(FLOW, "R7 store data fwd");
    @(negedge clk); cfg_fwd_alu = 1'b0; cfg_fwd_store = 1'b0; ex_rd = 5'd2; settle();
    expect_ctl(DSTL, "R7 store addr follows alu rule");
    @(negedge clk); cfg_fwd_alu = 1'b1; cfg_fwd_store = 1'b1; ex_rd = 5'd9; ex_is_load = 1'b1; settle();
    expect_ctl(DSTL, "R7 store data load EX");
  endtask

  task automatic t_ctl();
    @(negedge clk); idle_inputs(); id_cls = 3'd7; id_mispredict = 1'b1; id_reg_we = 1'b1; settle();
    expect_ctl(CSTL, "R8 control stall");
    expect_ex(3'b000, "R10 control bubble");
  endtask

  task automatic t_ignore();
    @(negedge clk); idle_inputs(); id_cls = 3'd1; id_rs1 = 5'd0; id_rs2 = 5'd0; prod_ex(5'd0, 1'b1);
    ma_rd = 5'd0; ma_reg_we = 1'b1; settle();
    expect_ctl(FLOW, "R9 register 0");
    @(negedge clk); id_rs1 = 5'd14; ex_rd = 5'd14; ex_reg_we = 1'b0; ma_rd = 5'd14; ma_reg_we = 1'b0; settle();
    expect_ctl(FLOW, "R9 no write flag");
    @(negedge clk); id_cls = 3'd2; id_rs1 = 5'd1; id_rs2 = 5'd14; ex_reg_we = 1'b1; settle();
    expect_ctl(FLOW, "R9 rs2 unused class2");
    @(negedge clk); id_cls = 3'd7; id_rs1 = 5'd14; settle();
    expect_ctl(FLOW, "R9 class7 reads none");
    @(negedge clk); id_cls = 3'd0; settle();
    expect_ctl(FLOW, "R9 class0 reads none");
  endtask

  task automatic t_bubble();
    @(negedge clk); idle_inputs(); id_cls = 3'd4; id_rs1 = 5'd11; id_mem_we = 1'b1; id_mem_re = 1'b1; id_reg_we = 1'b1;
    ma_rd = 5'd11; ma_reg_we = 1'b1; settle();
    expect_ctl(DSTL, "R2 data stall pattern");
    expect_ex(3'b000, "R10 data bubble");
  endtask

  task automatic t_prio();
    @(negedge clk); idle_inputs(); id_cls = 3'd6; id_rs1 = 5'd17; id_mispredict = 1'b1;
    prod_ex(5'd17, 1'b0); settle();
    expect_ctl(DSTL, "R11 data over control");
    @(negedge clk); ex_reg_we = 1'b0; settle();
    expect_ctl(CSTL, "R11 control once clear");
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_alu_nofwd();
    t_alu_fwd();
    t_jreg();
    t_brz();
    t_store();
    t_ctl();
    t_ignore();
    t_bubble();
    t_prio();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule